// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times one revolution pulse of a fan. It takes the fan's tach signal and counts reference ticks from one synchronized rising edge to the next. A slow fan produces a large result and a fast fan a small one. A two-bit control field divides the reference tick rate by 1, 2, 4 or 8, which stretches the measurable range toward slower fans. The 8-bit result saturates at full scale, and full scale means the fan has stopped or is nearly stopped. When a measurement completes, the block compares the result against a programmed limit and raises an alarm if the result is above it.

A mode input turns the same pin into a plain fan-fail level input. In that mode the two-bit control field no longer picks a divisor. Its low bit picks the active polarity of the fail signal, and the alarm follows the synchronized pin level. A surrounding monitor triggers each measurement with a one-cycle start strobe and reads back the count, the done pulse and the alarm.

Top module: `fan_tach_meter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `fan_count` is 0, `meas_done` is 0 and `fan_alarm` is 0. A reset during a measurement abandons it, and no done pulse follows.
- R2: In count mode (`level_mode`=0), a `meas_start` pulse arms the block. It then waits for a rising edge on the synchronized tach signal and counts scaled reference ticks until the next such rising edge. Every rising edge is seen through a two-flop synchronizer.
- R3: The count-mode divisor is taken from `div_ctl`: 00 selects 1, 01 selects 2, 10 selects 4 and 11 selects 8. The result equals floor(T/D), where T is the number of reference ticks in one tach period and D is the selected divisor.
- R4: The result saturates at 255 and never wraps. This holds when the period is too long for the counter. It also holds when no rising edge arrives at all, in which case the block finishes with 255 after 255 scaled ticks.
- R5: `meas_done` is a one-cycle pulse. It rises on the same edge that loads the new result into `fan_count`. `fan_count` does not change on any other edge.
- R6: In count mode, `fan_alarm` is updated with every done pulse. It becomes 1 when the new result is strictly greater than `cnt_limit` and 0 otherwise, so a result equal to the limit raises no alarm.
- R7: In level mode (`level_mode`=1), `fan_alarm` follows the synchronized tach level within three clock edges. When `div_ctl[0]`=0 the fail signal is active high. When `div_ctl[0]`=1 it is active low.
- R8: In level mode, `meas_start` is ignored. No done pulse is produced and `fan_count` keeps its previous value.
- R9: Only cycles with `ref_tick` high advance the measurement. A tach period of P clock cycles with `ref_tick` high on every other cycle gives P/2 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | 1 | Raw fan tach or fan-fail signal |
| ref_tick | input | 1 | Reference timebase enable, one clock wide |
| level_mode | input | 1 | 1 selects level fail mode, 0 selects count mode |
| div_ctl | input | 2 | Divisor select in count mode, polarity select in level mode |
| cnt_limit | input | CNT_W | Alarm threshold for the count |
| meas_start | input | 1 | One-cycle strobe that arms a measurement |
| fan_count | output | CNT_W | Last completed period count |
| meas_done | output | 1 | One-cycle pulse when `fan_count` is loaded |
| fan_alarm | output | 1 | Fan alarm |

## Verification
Most internal faults in this block show up as a wrong `fan_count` on the very next done pulse. A prescaler that counts the wrong way gives a result off by a factor of the divisor. A counter that wraps gives a small value where 255 is expected. A missed edge gives roughly twice the expected count. A state machine stuck armed produces no done pulse at all, which the bench reports as a timeout after a few thousand cycles. Polarity or synchronizer faults in level mode show up at `fan_alarm` within three clock edges of a change on the tach pin.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    // Width of the shared divisor / polarity control field
    localparam int CTL_W = 2;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } tach_state_e;

    // Configuration seen by the datapath
    typedef struct packed {
        logic             level_mode;
        logic [CTL_W-1:0] ctl;
    } tach_cfg_t;

    // Tick divisor selected by the control field in count mode
    function automatic int unsigned ctl_to_div(input logic [CTL_W-1:0] c);
        return 32'd1 << c;
    endfunction

    // Level mode: bit 0 of the control field set means the fail signal is active low
    function automatic logic fail_active(input logic lvl, input logic [CTL_W-1:0] c);
        return lvl ^ c[0];
    endfunction

endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level_o,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[0] <= 1'b0;
                else     sh[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[g] <= 1'b0;
                else     sh[g] <= sh[g-1];
            end
        end
    end

    assign level_o = sh[STAGES-1];
    assign rise_o  = sh[STAGES-1] & ~sh[STAGES];

    // A rising edge is reported for exactly one cycle
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fan_tach_prescale.sv
module fan_tach_prescale
    import fan_tach_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             ref_tick,
    input  logic [CTL_W-1:0] div_ctl,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] last;

    assign last   = PRE_W'(ctl_to_div(div_ctl) - 1);
    assign tick_o = ref_tick & (pre == last);

    always_ff @(posedge clk) begin
        if (rst || clear)  pre <= '0;
        else if (ref_tick) pre <= (pre == last) ? '0 : pre + 1'b1;
    end

    // The phase counter moves only on reference ticks (or a clear)
    assert_phase_gated_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(ref_tick) && !$past(clear)) |-> $stable(pre));

endmodule

// File: rtl/fan_tach_period.sv
module fan_tach_period
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             level_mode,
    input  logic             rise,
    input  logic             tick,
    output logic             clear_o,
    output logic             fin_o,
    output logic [CNT_W-1:0] fin_val_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - 1'b1;

    tach_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        fin_o     = 1'b0;
        fin_val_o = cnt;
        clear_o   = (state == ST_IDLE);
        case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (start && !level_mode) state_n = ST_ARM;
            end
            ST_ARM: begin
                if (level_mode) begin
                    state_n = ST_IDLE;
                end else if (rise) begin
                    state_n = ST_MEAS;
                    cnt_n   = '0;
                    clear_o = 1'b1;
                end else if (tick) begin
                    if (cnt == CNT_NEAR) begin
                        fin_o     = 1'b1;
                        fin_val_o = CNT_MAX;
                        state_n   = ST_IDLE;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_MEAS: begin
                if (level_mode) begin
                    state_n = ST_IDLE;
                end else if (rise) begin
                    fin_o     = 1'b1;
                    fin_val_o = cnt + CNT_W'(tick);
                    state_n   = ST_IDLE;
                end else if (tick) begin
                    if (cnt == CNT_NEAR) begin
                        fin_o     = 1'b1;
                        fin_val_o = CNT_MAX;
                        state_n   = ST_IDLE;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Within one state the running count never decreases, so it cannot wrap
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state == $past(state)) |-> cnt >= $past(cnt));

    // Finishing always returns the sequencer to idle
    assert_fin_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
        fin_o |=> state == ST_IDLE);

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tach_in,
    input  logic             ref_tick,
    input  logic             level_mode,
    input  logic [1:0]       div_ctl,
    input  logic [CNT_W-1:0] cnt_limit,
    input  logic             meas_start,
    output logic [CNT_W-1:0] fan_count,
    output logic             meas_done,
    output logic             fan_alarm
);
    tach_cfg_t        cfg;
    logic             s_level, s_rise;
    logic             tick, clr;
    logic             fin;
    logic [CNT_W-1:0] fin_val;

    assign cfg = '{level_mode: level_mode, ctl: div_ctl};

    fan_tach_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .din(tach_in),
        .level_o(s_level), .rise_o(s_rise)
    );

    fan_tach_prescale #(.PRE_W(PRE_W)) i_pre (
        .clk(clk), .rst(rst), .clear(clr), .ref_tick(ref_tick),
        .div_ctl(cfg.ctl), .tick_o(tick)
    );

    fan_tach_period #(.CNT_W(CNT_W)) i_period (
        .clk(clk), .rst(rst), .start(meas_start), .level_mode(cfg.level_mode),
        .rise(s_rise), .tick(tick), .clear_o(clr),
        .fin_o(fin), .fin_val_o(fin_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fan_count <= '0;
            meas_done <= 1'b0;
            fan_alarm <= 1'b0;
        end else begin
            meas_done <= fin;
            if (fin) fan_count <= fin_val;
            if (cfg.level_mode)
                fan_alarm <= fail_active(s_level, cfg.ctl);
            else if (fin)
                fan_alarm <= (fin_val > cnt_limit);
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        meas_done |=> !meas_done);

    assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !meas_done |-> $stable(fan_count));

    assert_alarm_cmp_R6: assert property (@(posedge clk) disable iff (rst)
        meas_done |-> fan_alarm == (fan_count > $past(cnt_limit)));

    assert_level_no_done_R8: assert property (@(posedge clk) disable iff (rst)
        $past(level_mode) |-> !meas_done);

    assert_tick_gated_R9: assert property (@(posedge clk) disable iff (rst)
        tick |-> ref_tick);

endmodule

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tach_in;
    logic       ref_tick;
    logic       level_mode = 1'b0;
    logic [1:0] div_ctl = 2'b00;
    logic [7:0] cnt_limit = 8'd0;
    logic       meas_start = 1'b0;
    logic [7:0] fan_count;
    logic       meas_done;
    logic       fan_alarm;

    int   tach_half  = 0;
    logic tach_level = 1'b0;
    logic ref_alt    = 1'b0;
    int   checks = 0;
    int   fails  = 0;

    always #2 clk = ~clk;

    fan_tach_meter i_fan_tach_meter (
        .clk(clk), .rst(rst), .tach_in(tach_in), .ref_tick(ref_tick),
        .level_mode(level_mode), .div_ctl(div_ctl), .cnt_limit(cnt_limit),
        .meas_start(meas_start), .fan_count(fan_count),
        .meas_done(meas_done), .fan_alarm(fan_alarm)
    );

    // Tach generator: square wave with tach_half cycles per half period, or a static level
    initial begin
        int ph = 0;
        tach_in = 1'b0;
        forever begin
            @(negedge clk);
            if (tach_half == 0) begin
                tach_in = tach_level;
                ph = 0;
            end else begin
                ph++;
                if (ph >= tach_half) begin
                    ph = 0;
                    tach_in = ~tach_in;
                end
            end
        end
    end

    // Reference tick: every cycle, or every other cycle
    initial begin
        ref_tick = 1'b1;
        forever begin
            @(negedge clk);
            ref_tick = ref_alt ? ~ref_tick : 1'b1;
        end
    end

    typedef struct packed {
        logic [15:0] half;
        logic [1:0]  div;
        logic [7:0]  lim;
        logic        alt;
        logic [7:0]  cnt;
        logic        alm;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'd50,  2'b00, 8'd153, 1'b0, 8'd100, 1'b0},  // R2 R3 divide by 1
        '{16'd50,  2'b01, 8'd40,  1'b0, 8'd50,  1'b1},  // R3 divide by 2, R6 alarm
        '{16'd153, 2'b01, 8'd153, 1'b0, 8'd153, 1'b0},  // R6 equal to limit, no alarm
        '{16'd155, 2'b01, 8'd153, 1'b0, 8'd155, 1'b1},  // R6 just above limit
        '{16'd200, 2'b10, 8'd200, 1'b0, 8'd100, 1'b0},  // R3 divide by 4
        '{16'd500, 2'b11, 8'd124, 1'b0, 8'd125, 1'b1},  // R3 divide by 8
        '{16'd513, 2'b11, 8'd200, 1'b0, 8'd128, 1'b0},  // R3 floor of 1026/8
        '{16'd254, 2'b01, 8'd255, 1'b0, 8'd254, 1'b0},  // R4 one below full scale
        '{16'd255, 2'b01, 8'd254, 1'b0, 8'd255, 1'b1},  // R4 exactly full scale
        '{16'd300, 2'b00, 8'd255, 1'b0, 8'd255, 1'b0},  // R4 saturate, R6 limit 255
        '{16'd100, 2'b00, 8'd99,  1'b1, 8'd100, 1'b1}   // R9 half-rate ticks
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_meas(input int half, input logic [1:0] dv, input logic [7:0] lim,
                            input logic alt, input int exp_cnt, input int exp_alm,
                            input string req);
        int n = 0;
        level_mode = 1'b0;
        div_ctl    = dv;
        cnt_limit  = lim;
        ref_alt    = alt;
        tach_level = 1'b0;
        tach_half  = half;
        repeat (4 * half + 10) @(negedge clk);
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        while (!meas_done && n < 30000) begin
            @(negedge clk);
            n++;
        end
        check(req, "done seen", int'(meas_done), 1);
        check(req, "count", int'(fan_count), exp_cnt);
        check("R6", "alarm", int'(fan_alarm), exp_alm);
        @(negedge clk);
        check("R5", "done one cycle", int'(meas_done), 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int saved;
        int seen;
        repeat (5) @(negedge clk);
        check("R1", "count in reset", int'(fan_count), 0);
        check("R1", "done in reset", int'(meas_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "count after reset", int'(fan_count), 0);
        check("R1", "done after reset", int'(meas_done), 0);
        check("R1", "alarm after reset", int'(fan_alarm), 0);

        for (int i = 0; i < NV; i++) begin
            run_meas(int'(VECS[i].half), VECS[i].div, VECS[i].lim, VECS[i].alt,
                     int'(VECS[i].cnt), int'(VECS[i].alm), "R2");
        end

        // R4: stopped fan, no rising edge at all
        run_meas(0, 2'b00, 8'd10, 1'b0, 255, 1, "R4");

        // R7: level mode with both polarities
        level_mode = 1'b1;
        tach_half  = 0;
        tach_level = 1'b1;
        div_ctl    = 2'b00;
        repeat (4) @(negedge clk);
        check("R7", "active high, pin high", int'(fan_alarm), 1);
        div_ctl = 2'b01;
        repeat (4) @(negedge clk);
        check("R7", "active low, pin high", int'(fan_alarm), 0);
        tach_level = 1'b0;
        repeat (4) @(negedge clk);
        check("R7", "active low, pin low", int'(fan_alarm), 1);
        div_ctl = 2'b00;
        repeat (4) @(negedge clk);
        check("R7", "active high, pin low", int'(fan_alarm), 0);

        // R8: start ignored in level mode
        saved = int'(fan_count);
        seen  = 0;
        tach_half = 20;
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (meas_done) seen = 1;
        end
        check("R8", "no done in level mode", seen, 0);
        check("R8", "count held", int'(fan_count), saved);

        // R1: reset in the middle of a measurement
        level_mode = 1'b0;
        tach_half  = 100;
        repeat (20) @(negedge clk);
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        repeat (150) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "count after mid reset", int'(fan_count), 0);
        check("R1", "alarm after mid reset", int'(fan_alarm), 0);
        seen = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (meas_done) seen = 1;
        end
        check("R1", "abandoned measurement gives no done", seen, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule